// File: doc/BRIEF.md
# Hardware Power-Down Pin Sequencer

This block watches an active-low power-down request pin and turns it into one of two outcomes, depending on how long the pin stays low. The pin is first brought into the local clock domain through a synchronizer. It is then examined only on machine-cycle strobes. A low level caught on a single strobe produces a plain internal reset that releases after a fixed hold time. A low level caught on two consecutive strobes puts the chip into hardware power-down: the internal reset stays asserted, every port output is floated and the main clock is asked to stop.

Leaving power-down is sequenced. When a strobe sees the pin high again, the clock stop request drops so that the main oscillator can restart. The block then waits for the backup RC reference to report ready, then for the main oscillator to report ready. It then holds reset and the port float for a fixed count before it releases both together. The block runs on a clock that keeps running during power-down. The oscillators themselves and the pads are outside it; their readiness arrives as plain input flags.

Top module: `pdseq_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released with the pin high, `int_reset`, `port_float` and `clk_stop` are all 0.
- R2: `pd_req_n` passes through a two-stage synchronizer and is acted on only at a clock edge where `mc_tick` is 1. A low level that reaches the synchronizer output only between strobes has no effect on any output.
- R3: The first strobe that sees the synchronized pin low asserts `int_reset` from the next cycle, with `port_float` and `clk_stop` still 0.
- R4: If the strobe after a single low sample sees the pin high, `int_reset` stays high for the rest of that strobe period plus exactly HOLD_CYCLES (24) clock cycles, and `port_float` never rises.
- R5: Two consecutive strobes that see the pin low enter power-down. From the next cycle `clk_stop`, `port_float` and `int_reset` are all 1, and `clk_stop` is never 1 without `port_float`.
- R6: In power-down, a strobe that sees the pin high clears `clk_stop` while `port_float` and `int_reset` stay 1. The block then waits for `rc_ready` = 1, and only after that for `osc_ready` = 1. An `osc_ready` that arrives first does not shorten the wait.
- R7: From the cycle after `osc_ready` is seen, `port_float` and `int_reset` stay 1 for exactly HOLD_CYCLES (24) more cycles and fall in the same cycle. `port_float` is never 1 while `int_reset` is 0.
- R8: A strobe that sees the pin low at any point of the exit sequence returns the block to power-down at once, setting `clk_stop` again.
- R9: A strobe that sees the pin low during the short-pulse reset hold starts the evaluation again. The reset is extended, and a second consecutive low sample would enter power-down.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Always-running sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_req_n | input | 1 | Asynchronous power-down request pin, active low |
| mc_tick | input | 1 | One-cycle strobe marking each machine cycle |
| rc_ready | input | 1 | Backup RC reference oscillator is running |
| osc_ready | input | 1 | Main oscillator is stable |
| int_reset | output | 1 | Internal reset, active high |
| port_float | output | 1 | Tri-state all port outputs |
| clk_stop | output | 1 | Request to stop the main clock |

## Verification
On every cycle the assertions check how the three outputs relate to each other: the clock stop implies the float, the float implies the reset, and the float and reset are released together. They also check that power-down is entered only from a pending low sample or from an exit state, that the oscillator wait is passed only after the RC flag was seen, and that the hold counter stays in range. The counting behaviour can only be shown by the bench scenarios, by comparison with the reference model: strobe-qualified sampling and the ignoring of glitches between strobes, the one-sample versus two-sample split, the exact 24-cycle holds, the ready-flag ordering, and the re-entry into power-down or re-arming during a hold.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

    typedef enum logic [2:0] {
        PS_RUN       = 3'd0,
        PS_ARMED     = 3'd1,
        PS_PWRDN     = 3'd2,
        PS_WAIT_RC   = 3'd3,
        PS_WAIT_OSC  = 3'd4,
        PS_HOLD_RST  = 3'd5,
        PS_HOLD_EXIT = 3'd6
    } pd_state_e;

    typedef struct packed {
        logic int_reset;
        logic port_float;
        logic clk_stop;
    } pd_ctrl_t;

    function automatic logic is_exit_state(pd_state_e s);
        return (s == PS_WAIT_RC) || (s == PS_WAIT_OSC) || (s == PS_HOLD_EXIT);
    endfunction

    function automatic logic is_hold_state(pd_state_e s);
        return (s == PS_HOLD_RST) || (s == PS_HOLD_EXIT);
    endfunction

    function automatic pd_ctrl_t decode_ctrl(pd_state_e s);
        pd_ctrl_t c;
        c.int_reset  = (s != PS_RUN);
        c.port_float = (s == PS_PWRDN) || is_exit_state(s);
        c.clk_stop   = (s == PS_PWRDN);
        return c;
    endfunction

endpackage

// File: rtl/pdseq_sync.sv
module pdseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '1;
        else     chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/pdseq_timer.sv
module pdseq_timer #(
    parameter int HOLD_CYCLES = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int CW = $clog2(HOLD_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

    logic [CW-1:0] cnt_q;

    assign done = run && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || done) cnt_q <= '0;
        else                     cnt_q <= cnt_q + CW'(1);
    end

    a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    a_r4_idle_cleared: assert property (@(posedge clk) disable iff (rst)
        !$past(run) |-> (cnt_q == '0));
endmodule

// File: rtl/pdseq_fsm.sv
module pdseq_fsm
    import pdseq_pkg::*;
#(
    parameter int ENTER_SAMPLES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  logic     pin_low,
    input  logic     rc_ready,
    input  logic     osc_ready,
    input  logic     hold_done,
    output logic     hold_run,
    output pd_ctrl_t ctrl
);
    localparam int LW = $clog2(ENTER_SAMPLES + 1);
    localparam logic [LW-1:0] ENTER_N = LW'(ENTER_SAMPLES);

    pd_state_e     st_q, st_d;
    logic [LW-1:0] low_q, low_d;
    logic          low_tick, high_tick;

    assign low_tick  = tick &  pin_low;
    assign high_tick = tick & ~pin_low;

    always_comb begin
        st_d  = st_q;
        low_d = low_q;
        case (st_q)
            PS_RUN, PS_HOLD_RST: begin
                if (low_tick) begin
                    low_d = LW'(1);
                    st_d  = (LW'(1) >= ENTER_N) ? PS_PWRDN : PS_ARMED;
                end else if (st_q == PS_HOLD_RST && hold_done) begin
                    st_d = PS_RUN;
                end
            end
            PS_ARMED: begin
                if (low_tick) begin
                    low_d = low_q + LW'(1);
                    if (low_q + LW'(1) >= ENTER_N) st_d = PS_PWRDN;
                end else if (high_tick) begin
                    st_d = PS_HOLD_RST;
                end
            end
            PS_PWRDN: begin
                if (high_tick) st_d = PS_WAIT_RC;
            end
            PS_WAIT_RC: begin
                if (low_tick)      st_d = PS_PWRDN;
                else if (rc_ready) st_d = PS_WAIT_OSC;
            end
            PS_WAIT_OSC: begin
                if (low_tick)       st_d = PS_PWRDN;
                else if (osc_ready) st_d = PS_HOLD_EXIT;
            end
            PS_HOLD_EXIT: begin
                if (low_tick)       st_d = PS_PWRDN;
                else if (hold_done) st_d = PS_RUN;
            end
            default: st_d = PS_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PS_RUN;
            low_q <= '0;
        end else begin
            st_q  <= st_d;
            low_q <= low_d;
        end
    end

    assign hold_run = is_hold_state(st_q);
    assign ctrl     = decode_ctrl(st_q);

    // R5: the clock is never stopped while the ports are driven
    a_r5_stop_needs_float: assert property (@(posedge clk) disable iff (rst)
        ctrl.clk_stop |-> ctrl.port_float);

    // R7: floated ports always come with reset held
    a_r7_float_needs_reset: assert property (@(posedge clk) disable iff (rst)
        ctrl.port_float |-> ctrl.int_reset);

    // R7: float and reset are released in one cycle
    a_r7_release_together: assert property (@(posedge clk) disable iff (rst)
        $fell(ctrl.port_float) |-> $fell(ctrl.int_reset));

    // R5 / R8: power-down is entered only from a pending sample or an exit state
    a_r5_entry_source: assert property (@(posedge clk) disable iff (rst)
        $rose(ctrl.clk_stop) |-> ($past(st_q) == PS_ARMED || is_exit_state($past(st_q))));

    // R6: the oscillator wait is reached only with the RC reference seen ready
    a_r6_rc_before_osc: assert property (@(posedge clk) disable iff (rst)
        (st_q == PS_WAIT_OSC && $past(st_q) == PS_WAIT_RC) |-> $past(rc_ready));

    // R4: the short-pulse path never floats the ports
    a_r4_short_no_float: assert property (@(posedge clk) disable iff (rst)
        (st_q == PS_HOLD_RST || st_q == PS_ARMED) |-> !ctrl.port_float);
endmodule

// File: rtl/pdseq_top.sv
module pdseq_top
    import pdseq_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int ENTER_SAMPLES = 2,
    parameter int HOLD_CYCLES   = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic pd_req_n,
    input  logic mc_tick,
    input  logic rc_ready,
    input  logic osc_ready,
    output logic int_reset,
    output logic port_float,
    output logic clk_stop
);
    logic     pin_sync;
    logic     hold_run;
    logic     hold_done;
    pd_ctrl_t ctrl;

    pdseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (pd_req_n),
        .dout (pin_sync)
    );

    pdseq_timer #(.HOLD_CYCLES(HOLD_CYCLES)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (hold_run),
        .done (hold_done)
    );

    pdseq_fsm #(.ENTER_SAMPLES(ENTER_SAMPLES)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .tick      (mc_tick),
        .pin_low   (~pin_sync),
        .rc_ready  (rc_ready),
        .osc_ready (osc_ready),
        .hold_done (hold_done),
        .hold_run  (hold_run),
        .ctrl      (ctrl)
    );

    assign int_reset  = ctrl.int_reset;
    assign port_float = ctrl.port_float;
    assign clk_stop   = ctrl.clk_stop;
endmodule

// File: tb/pdseq_top_bench.sv
module pdseq_top_bench;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int HOLD       = 24;
    localparam int WATCHDOG   = 50000;

    // model state codes (bench-local)
    localparam int M_RUN = 0, M_ARM = 1, M_PD = 2, M_WRC = 3, M_WOSC = 4, M_HRST = 5, M_HEX = 6;

    logic clk = 1'b0;
    logic rst, pd_req_n, mc_tick, rc_ready, osc_ready;
    logic int_reset, port_float, clk_stop;

    int checks = 0, fails = 0, cyc = 0, tcnt = 0;
    int nres, nflt, nstop;
    bit done = 0;
    string cur_req = "R1";

    int m_st = M_RUN, m_cnt = 0;
    bit p1 = 1, p2 = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    pdseq_top u_pdseq_top (
        .clk(clk), .rst(rst), .pd_req_n(pd_req_n), .mc_tick(mc_tick),
        .rc_ready(rc_ready), .osc_ready(osc_ready),
        .int_reset(int_reset), .port_float(port_float), .clk_stop(clk_stop)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d (t=%0t)", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (rst) begin
            m_st = M_RUN; m_cnt = 0; p1 = 1; p2 = 1;
        end else begin
            bit lo, hi;
            lo = mc_tick && !p2;
            hi = mc_tick && p2;
            case (m_st)
                M_RUN:  if (lo) m_st = M_ARM;
                M_ARM:  if (lo) m_st = M_PD; else if (hi) begin m_st = M_HRST; m_cnt = 0; end
                M_PD:   if (hi) m_st = M_WRC;
                M_WRC:  if (lo) m_st = M_PD; else if (rc_ready) m_st = M_WOSC;
                M_WOSC: if (lo) m_st = M_PD; else if (osc_ready) begin m_st = M_HEX; m_cnt = 0; end
                M_HRST: if (lo) m_st = M_ARM;
                        else if (m_cnt == HOLD-1) m_st = M_RUN; else m_cnt++;
                M_HEX:  if (lo) m_st = M_PD;
                        else if (m_cnt == HOLD-1) m_st = M_RUN; else m_cnt++;
                default: m_st = M_RUN;
            endcase
            p2 = p1; p1 = pd_req_n;
        end
    end

    // cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!rst && !done) begin
            int er, ef, es;
            er = (m_st != M_RUN);
            ef = (m_st == M_PD || m_st == M_WRC || m_st == M_WOSC || m_st == M_HEX);
            es = (m_st == M_PD);
            check(int_reset  == er, cur_req, "int_reset vs model",  int_reset,  er);
            check(port_float == ef, cur_req, "port_float vs model", port_float, ef);
            check(clk_stop   == es, cur_req, "clk_stop vs model",   clk_stop,   es);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > WATCHDOG && !done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic step();
        @(negedge clk);
        tcnt = (tcnt + 1) % TICK_DIV;
        mc_tick = (tcnt == 0);
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            step();
            nres  += int'(int_reset);
            nflt  += int'(port_float);
            nstop += int'(clk_stop);
        end
    endtask

    task automatic clr();
        nres = 0; nflt = 0; nstop = 0;
    endtask

    task automatic align();
        do step(); while (!mc_tick);
    endtask

    initial begin
        rst = 1; pd_req_n = 1; mc_tick = 0; rc_ready = 0; osc_ready = 0;
        repeat (4) step();
        check(int_reset == 0 && port_float == 0 && clk_stop == 0, "R1", "outputs in reset",
              {int_reset, port_float, clk_stop}, 0);
        rst = 0;
        step();
        check({int_reset, port_float, clk_stop} == 3'b000, "R1", "outputs after reset",
              {int_reset, port_float, clk_stop}, 0);

        // R2: one-clock glitch landing between strobes
        cur_req = "R2";
        align(); pd_req_n = 0; clr();
        run(1); pd_req_n = 1; run(16);
        check(nres == 0, "R2", "reset cycles after glitch", nres, 0);

        // R3/R4: single low sample
        cur_req = "R4";
        align(); pd_req_n = 0; clr();
        run(4); pd_req_n = 1; run(1);
        check(int_reset == 1 && port_float == 0 && clk_stop == 0, "R3", "first sample outputs",
              {int_reset, port_float, clk_stop}, 3'b100);
        run(59);
        check(nres == TICK_DIV + HOLD, "R4", "short reset length", nres, TICK_DIV + HOLD);
        check(nflt == 0, "R4", "float during short reset", nflt, 0);

        // R5: sustained low
        cur_req = "R5";
        align(); pd_req_n = 0;
        run(12);
        check({int_reset, port_float, clk_stop} == 3'b111, "R5", "power-down outputs",
              {int_reset, port_float, clk_stop}, 3'b111);

        // R6: exit ordering, oscillator flag early
        cur_req = "R6";
        pd_req_n = 1; run(12);
        check(clk_stop == 0 && port_float == 1 && int_reset == 1, "R6", "clock restart, still floated",
              {int_reset, port_float, clk_stop}, 3'b110);
        osc_ready = 1; run(30);
        check(port_float == 1 && int_reset == 1, "R6", "waiting for RC flag", port_float, 1);

        // R7: hold after both flags
        cur_req = "R7";
        rc_ready = 1; clr(); run(40);
        check(nflt == 1 + HOLD, "R7", "float cycles after RC ready", nflt, 1 + HOLD);
        check(nres == nflt, "R7", "reset and float release together", nres, nflt);
        check(int_reset == 0 && port_float == 0, "R7", "released", {int_reset, port_float}, 0);

        // R8: pin low again during exit hold
        cur_req = "R8";
        align(); pd_req_n = 0; run(12);
        check(clk_stop == 1, "R8", "back in power-down", clk_stop, 1);
        pd_req_n = 1; run(8);
        check(clk_stop == 0 && port_float == 1, "R8", "in exit sequence", {port_float, clk_stop}, 2'b10);
        pd_req_n = 0; run(8);
        check(clk_stop == 1 && port_float == 1, "R8", "re-entered power-down", {port_float, clk_stop}, 2'b11);
        pd_req_n = 1; run(50);
        check(int_reset == 0 && port_float == 0 && clk_stop == 0, "R8", "final release",
              {int_reset, port_float, clk_stop}, 0);

        // R9: second short pulse during the short-reset hold
        cur_req = "R9";
        align(); pd_req_n = 0; run(4); pd_req_n = 1; run(12);
        align(); pd_req_n = 0; run(4); pd_req_n = 1; run(25);
        check(int_reset == 1 && port_float == 0, "R9", "reset extended by re-arm",
              {int_reset, port_float}, 2'b10);
        run(40);
        check(int_reset == 0, "R9", "released after extended hold", int_reset, 0);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule